// File: doc/BRIEF.md
# Programmable ATA PIO Strobe Timer

This block runs one programmed-I/O cycle on an ATA device each time it is asked to. A request carries the direction, the device register address, which of the two chip selects to use and, for a write, the 16-bit word. The engine then drives the address and chip select, pulses the read or write strobe low, holds the bus, waits out a recovery gap, and reports the end with a one-cycle done pulse. A read returns the captured 16-bit word with that pulse.

Every phase length is a count of system clock cycles taken from configuration inputs. The same engine therefore covers the slowest and fastest PIO modes, and the clock frequency only changes the counts. A device that pulls its ready line low stretches the strobe. A programmable limit ends the stretch and flags a timeout. The engine also drives a separate active-low device reset line from a level input.

Top module: `pio_strobe_timer`

## Requirements
- R1: While reset is applied and after it is released, both chip selects, both strobes and the ready-for-request indication are inactive: chip selects high, strobes high, output enable low, busy low, done low. The device reset output is low during reset.
- R2: A request is accepted only while busy is low. Acceptance happens when `req` is high at a clock edge. From the next cycle, `ata_addr` shows the request address and one chip select goes low (`req_sel`=0 selects `ata_cs0_n`, 1 selects `ata_cs1_n`). Both strobes stay high for a setup phase of `cfg_t1` cycles.
- R3: The strobe phase follows setup and lasts `cfg_t2` cycles. During it, `ata_rd_n` is low for a read (`req_wr`=0) or `ata_wr_n` is low for a write (`req_wr`=1). The two strobes are never low together.
- R4: `ata_rdy` is sampled in the last cycle of the strobe phase. If it is low, the strobe stays low, one cycle at a time, up to and including the cycle in which `ata_rdy` is sampled high.
- R5: The stretch lasts at most `cfg_tiordy` cycles. If ready is still low in the last allowed cycle, the strobe is released anyway and `done_tmo` is high with done.
- R6: After the strobe comes a hold phase of `cfg_t3` cycles, with the chip select still low and both strobes high. A recovery phase of `cfg_t4` cycles follows with the chip selects high. Done is then high for exactly one cycle, in which busy is already low.
- R7: For a read, `done_rdata` equals the value on `ata_din` at the clock edge that ends the last strobe-low cycle.
- R8: For a write, `ata_doe` is high from the first setup cycle through the last hold cycle, with `ata_dout` equal to the request word. At all other times `ata_doe` is low. For a read, `ata_doe` stays low.
- R9: A count of zero in any of `cfg_t1`..`cfg_t4` or `cfg_tiordy` behaves as a count of one.
- R10: While busy, `req` and any change of request fields or of `cfg_t1`..`cfg_tiordy` have no effect on the cycle in progress. The counts are taken at acceptance.
- R11: `ata_rst_n` is the inverse of `dev_rst_hold`, delayed by one clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| req | input | 1 | Start one PIO cycle (taken when idle) |
| req_wr | input | 1 | 1 = write, 0 = read |
| req_sel | input | 1 | Chip select choice: 0 = cs0, 1 = cs1 |
| req_addr | input | 3 | Device register address |
| req_wdata | input | 16 | Write word |
| cfg_t1 | input | CNT_W | Setup length in cycles |
| cfg_t2 | input | CNT_W | Strobe length in cycles |
| cfg_t3 | input | CNT_W | Hold length in cycles |
| cfg_t4 | input | CNT_W | Recovery length in cycles |
| cfg_tiordy | input | TMO_W | Maximum ready stretch in cycles |
| dev_rst_hold | input | 1 | Level request to hold the device in reset |
| ata_din | input | 16 | Read data from the device |
| ata_rdy | input | 1 | Device ready, high = ready |
| busy | output | 1 | A cycle is in progress |
| ata_addr | output | 3 | Device register address |
| ata_cs0_n | output | 1 | Chip select 0, active low |
| ata_cs1_n | output | 1 | Chip select 1, active low |
| ata_rd_n | output | 1 | Read strobe, active low |
| ata_wr_n | output | 1 | Write strobe, active low |
| ata_dout | output | 16 | Write data toward the device |
| ata_doe | output | 1 | Drive enable for ata_dout, active high |
| ata_rst_n | output | 1 | Device reset, active low |
| done | output | 1 | One-cycle end-of-cycle pulse |
| done_rdata | output | 16 | Captured read word, valid with done |
| done_tmo | output | 1 | Ready timeout, valid with done |

## Verification
The bench holds ready low until a chosen cycle, either inside the allowed stretch or past it. An engine that samples ready one cycle late, or that counts the limit off by one, would show a strobe that is a cycle too long or too short. The bench drives the correct read word only in the strobe's final cycle, so a capture on the wrong edge returns the complement. Zero counts check that no phase collapses to nothing or wraps to a huge length. A request pulse and scrambled configuration mid-cycle check that nothing is re-latched: a design that did so would show a changed address or phase length.

// File: rtl/pio_timer_pkg.sv
package pio_timer_pkg;

  localparam int PIO_CNT_W = 8;
  localparam int PIO_TMO_W = 10;

  typedef enum logic [2:0] {
    ST_IDLE   = 3'd0,
    ST_SETUP  = 3'd1,
    ST_STROBE = 3'd2,
    ST_WAIT   = 3'd3,
    ST_HOLD   = 3'd4,
    ST_RECOV  = 3'd5
  } pio_state_e;

  typedef enum logic [1:0] {
    LEN_SETUP = 2'd0,
    LEN_PULSE = 2'd1,
    LEN_HOLD  = 2'd2,
    LEN_RECOV = 2'd3
  } pio_len_e;

endpackage

// File: rtl/pio_len_ctr.sv
// Down counter for one phase; a loaded zero is treated as one.
module pio_len_ctr #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_val,
  input  logic         dec,
  output logic         last
);
  localparam logic [W-1:0] ONE = W'(1);

  logic [W-1:0] cnt_q;
  logic [W-1:0] cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (load)
      cnt_d = (load_val == '0) ? ONE : load_val;
    else if (dec && cnt_q != '0)
      cnt_d = cnt_q - ONE;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign last = (cnt_q == ONE);
endmodule

// File: rtl/pio_seq_fsm.sv
// Phase sequencer: setup, strobe, optional ready stretch, hold, recovery.
module pio_seq_fsm
  import pio_timer_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       req,
  input  logic       ph_last,
  input  logic       wt_last,
  input  logic       rdy,
  output pio_state_e state,
  output logic       accept,
  output logic       ld_ph,
  output pio_len_e   ld_sel,
  output logic       ld_wt,
  output logic       cap,
  output logic       tmo_hit,
  output logic       fin
);
  pio_state_e st_q, st_d;

  always_comb begin
    st_d    = st_q;
    accept  = 1'b0;
    ld_ph   = 1'b0;
    ld_sel  = LEN_SETUP;
    ld_wt   = 1'b0;
    cap     = 1'b0;
    tmo_hit = 1'b0;
    fin     = 1'b0;
    unique case (st_q)
      ST_IDLE: if (req) begin
        st_d   = ST_SETUP;
        accept = 1'b1;
        ld_ph  = 1'b1;
        ld_sel = LEN_SETUP;
      end
      ST_SETUP: if (ph_last) begin
        st_d   = ST_STROBE;
        ld_ph  = 1'b1;
        ld_sel = LEN_PULSE;
      end
      ST_STROBE: if (ph_last) begin
        if (rdy) begin
          st_d   = ST_HOLD;
          ld_ph  = 1'b1;
          ld_sel = LEN_HOLD;
          cap    = 1'b1;
        end else begin
          st_d  = ST_WAIT;
          ld_wt = 1'b1;
        end
      end
      ST_WAIT: if (rdy || wt_last) begin
        st_d    = ST_HOLD;
        ld_ph   = 1'b1;
        ld_sel  = LEN_HOLD;
        cap     = 1'b1;
        tmo_hit = !rdy;
      end
      ST_HOLD: if (ph_last) begin
        st_d   = ST_RECOV;
        ld_ph  = 1'b1;
        ld_sel = LEN_RECOV;
      end
      ST_RECOV: if (ph_last) begin
        st_d = ST_IDLE;
        fin  = 1'b1;
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= ST_IDLE;
    else        st_q <= st_d;
  end

  assign state = st_q;
endmodule

// File: rtl/pio_strobe_timer.sv
module pio_strobe_timer
  import pio_timer_pkg::*;
#(
  parameter int CNT_W  = PIO_CNT_W,
  parameter int TMO_W  = PIO_TMO_W,
  parameter int ADDR_W = 3,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req,
  input  logic              req_wr,
  input  logic              req_sel,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  input  logic [CNT_W-1:0]  cfg_t1,
  input  logic [CNT_W-1:0]  cfg_t2,
  input  logic [CNT_W-1:0]  cfg_t3,
  input  logic [CNT_W-1:0]  cfg_t4,
  input  logic [TMO_W-1:0]  cfg_tiordy,
  input  logic              dev_rst_hold,
  input  logic [DATA_W-1:0] ata_din,
  input  logic              ata_rdy,
  output logic              busy,
  output logic [ADDR_W-1:0] ata_addr,
  output logic              ata_cs0_n,
  output logic              ata_cs1_n,
  output logic              ata_rd_n,
  output logic              ata_wr_n,
  output logic [DATA_W-1:0] ata_dout,
  output logic              ata_doe,
  output logic              ata_rst_n,
  output logic              done,
  output logic [DATA_W-1:0] done_rdata,
  output logic              done_tmo
);
  localparam int SYNC_STAGES = 2;

  // Reset: asserted asynchronously, released on the clock.
  logic [SYNC_STAGES-1:0] rsync_q;
  logic                   irst_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsync_q <= '0;
    else        rsync_q <= {rsync_q[SYNC_STAGES-2:0], 1'b1};
  end
  assign irst_n = rsync_q[SYNC_STAGES-1];

  // Sequencer and counters.
  pio_state_e state;
  logic       accept, ld_ph, ld_wt, cap, tmo_hit, fin;
  pio_len_e   ld_sel;
  logic       ph_last, wt_last;

  // Request fields and counts held for the whole cycle.
  logic              wr_q, sel_q;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] wdata_q;
  logic [CNT_W-1:0]  t2_q, t3_q, t4_q;
  logic [TMO_W-1:0]  tmo_q;
  logic [CNT_W-1:0]  ph_val;

  pio_seq_fsm u_fsm (
    .clk     (clk),
    .rst_n   (irst_n),
    .req     (req),
    .ph_last (ph_last),
    .wt_last (wt_last),
    .rdy     (ata_rdy),
    .state   (state),
    .accept  (accept),
    .ld_ph   (ld_ph),
    .ld_sel  (ld_sel),
    .ld_wt   (ld_wt),
    .cap     (cap),
    .tmo_hit (tmo_hit),
    .fin     (fin)
  );

  always_comb begin
    unique case (ld_sel)
      LEN_SETUP: ph_val = cfg_t1;
      LEN_PULSE: ph_val = t2_q;
      LEN_HOLD:  ph_val = t3_q;
      default:   ph_val = t4_q;
    endcase
  end

  pio_len_ctr #(.W(CNT_W)) u_ph_ctr (
    .clk      (clk),
    .rst_n    (irst_n),
    .load     (ld_ph),
    .load_val (ph_val),
    .dec      (!ld_ph),
    .last     (ph_last)
  );

  pio_len_ctr #(.W(TMO_W)) u_wt_ctr (
    .clk      (clk),
    .rst_n    (irst_n),
    .load     (ld_wt),
    .load_val (tmo_q),
    .dec      (state == ST_WAIT),
    .last     (wt_last)
  );

  // Latch on acceptance.
  always_ff @(posedge clk or negedge irst_n) begin
    if (!irst_n) begin
      wr_q    <= 1'b0;
      sel_q   <= 1'b0;
      addr_q  <= '0;
      wdata_q <= '0;
      t2_q    <= '0;
      t3_q    <= '0;
      t4_q    <= '0;
      tmo_q   <= '0;
    end else if (accept) begin
      wr_q    <= req_wr;
      sel_q   <= req_sel;
      addr_q  <= req_addr;
      wdata_q <= req_wdata;
      t2_q    <= cfg_t2;
      t3_q    <= cfg_t3;
      t4_q    <= cfg_t4;
      tmo_q   <= cfg_tiordy;
    end
  end

  // Result registers.
  logic [DATA_W-1:0] rdata_q;
  logic              tflag_q, done_q, drst_q;

  always_ff @(posedge clk or negedge irst_n) begin
    if (!irst_n)  rdata_q <= '0;
    else if (cap) rdata_q <= ata_din;
  end

  always_ff @(posedge clk or negedge irst_n) begin
    if (!irst_n)      tflag_q <= 1'b0;
    else if (accept)  tflag_q <= 1'b0;
    else if (tmo_hit) tflag_q <= 1'b1;
  end

  always_ff @(posedge clk or negedge irst_n) begin
    if (!irst_n) begin
      done_q <= 1'b0;
      drst_q <= 1'b0;
    end else begin
      done_q <= fin;
      drst_q <= !dev_rst_hold;
    end
  end

  // Output decode from held state.
  logic cs_on, strb_on;
  assign cs_on   = (state == ST_SETUP) || (state == ST_STROBE) ||
                   (state == ST_WAIT)  || (state == ST_HOLD);
  assign strb_on = (state == ST_STROBE) || (state == ST_WAIT);

  assign busy       = (state != ST_IDLE);
  assign ata_addr   = addr_q;
  assign ata_cs0_n  = !(cs_on && !sel_q);
  assign ata_cs1_n  = !(cs_on && sel_q);
  assign ata_rd_n   = !(strb_on && !wr_q);
  assign ata_wr_n   = !(strb_on && wr_q);
  assign ata_dout   = wdata_q;
  assign ata_doe    = cs_on && wr_q;
  assign ata_rst_n  = drst_q;
  assign done       = done_q;
  assign done_rdata = rdata_q;
  assign done_tmo   = done_q && tflag_q;
endmodule

// File: rtl/pio_strobe_timer_chk.sv
module pio_strobe_timer_chk #(
  parameter int ADDR_W = 3,
  parameter int DATA_W = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req,
  input logic              busy,
  input logic [ADDR_W-1:0] ata_addr,
  input logic              ata_cs0_n,
  input logic              ata_cs1_n,
  input logic              ata_rd_n,
  input logic              ata_wr_n,
  input logic [DATA_W-1:0] ata_dout,
  input logic              ata_doe,
  input logic              done
);
  p_one_strobe_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !(!ata_rd_n && !ata_wr_n));

  p_single_cs_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !(!ata_cs0_n && !ata_cs1_n));

  p_strobe_in_cs_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!ata_rd_n || !ata_wr_n) |-> (!ata_cs0_n || !ata_cs1_n));

  p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (ata_cs0_n && ata_cs1_n && ata_rd_n && ata_wr_n && !ata_doe));

  p_done_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  p_busy_end_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> done);

  p_doe_no_read_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ata_doe |-> ata_rd_n);

  p_dout_steady_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (ata_doe && $past(ata_doe)) |-> $stable(ata_dout));

  p_ignore_busy_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy) && $past(req)) |-> $stable(ata_addr));
endmodule

bind pio_strobe_timer pio_strobe_timer_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .req       (req),
  .busy      (busy),
  .ata_addr  (ata_addr),
  .ata_cs0_n (ata_cs0_n),
  .ata_cs1_n (ata_cs1_n),
  .ata_rd_n  (ata_rd_n),
  .ata_wr_n  (ata_wr_n),
  .ata_dout  (ata_dout),
  .ata_doe   (ata_doe),
  .done      (done)
);

// File: tb/sim_pio_strobe_timer.sv
module sim_pio_strobe_timer;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        req, req_wr, req_sel;
  logic [2:0]  req_addr;
  logic [15:0] req_wdata;
  logic [7:0]  cfg_t1, cfg_t2, cfg_t3, cfg_t4;
  logic [9:0]  cfg_tiordy;
  logic        dev_rst_hold;
  logic [15:0] ata_din;
  logic        ata_rdy;
  logic        busy, ata_cs0_n, ata_cs1_n, ata_rd_n, ata_wr_n, ata_doe, ata_rst_n;
  logic        done, done_tmo;
  logic [2:0]  ata_addr;
  logic [15:0] ata_dout, done_rdata;

  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pio_strobe_timer u0 (
    .clk(clk), .rst_n(rst_n), .req(req), .req_wr(req_wr), .req_sel(req_sel),
    .req_addr(req_addr), .req_wdata(req_wdata),
    .cfg_t1(cfg_t1), .cfg_t2(cfg_t2), .cfg_t3(cfg_t3), .cfg_t4(cfg_t4),
    .cfg_tiordy(cfg_tiordy), .dev_rst_hold(dev_rst_hold),
    .ata_din(ata_din), .ata_rdy(ata_rdy), .busy(busy), .ata_addr(ata_addr),
    .ata_cs0_n(ata_cs0_n), .ata_cs1_n(ata_cs1_n), .ata_rd_n(ata_rd_n),
    .ata_wr_n(ata_wr_n), .ata_dout(ata_dout), .ata_doe(ata_doe),
    .ata_rst_n(ata_rst_n), .done(done), .done_rdata(done_rdata), .done_tmo(done_tmo)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s t=%0t actual %h expected %h", tag, $time, act, exp);
    end
  endtask

  function automatic int eff(input int v);
    return (v == 0) ? 1 : v;
  endfunction

  // One PIO cycle against a behavioural per-cycle model.
  // lat: strobe cycles past the programmed length before ready returns high.
  task automatic run_txn(input logic wr, input logic sel, input logic [2:0] a,
                         input logic [15:0] wd, input logic [15:0] rd,
                         input int t1, input int t2, input int t3, input int t4,
                         input int to, input int lat, input int glitch);
    int e1, e2, e3, e4, eto, w, total, pe_strb, pe_hold;
    logic exp_tmo;
    e1 = eff(t1); e2 = eff(t2); e3 = eff(t3); e4 = eff(t4); eto = eff(to);
    w = (lat <= eto) ? lat : eto;
    exp_tmo = (lat > eto);
    pe_strb = e1 + e2 + w;
    pe_hold = pe_strb + e3;
    total = pe_hold + e4;

    @(negedge clk);
    chk("R2 idle before request", busy, 1'b0);
    req = 1'b1; req_wr = wr; req_sel = sel; req_addr = a; req_wdata = wd;
    cfg_t1 = t1[7:0]; cfg_t2 = t2[7:0]; cfg_t3 = t3[7:0]; cfg_t4 = t4[7:0];
    cfg_tiordy = to[9:0];
    ata_rdy = 1'b1; ata_din = ~rd;

    for (int n = 0; n <= total; n++) begin
      @(negedge clk);
      req = 1'b0;
      if (n == 0) begin
        // R10: counts and fields are scrambled after acceptance.
        cfg_t1 = 8'(t1 + 3); cfg_t2 = 8'(t2 + 2); cfg_t3 = 8'(t3 + 4);
        cfg_t4 = 8'(t4 + 1); cfg_tiordy = 10'(to + 5);
        req_addr = ~a; req_wdata = ~wd; req_sel = ~sel; req_wr = ~wr;
      end
      if (n == glitch) req = 1'b1;
      if (n < total) begin
        logic cs_on, strb;
        cs_on = (n < pe_hold);
        strb  = (n >= e1) && (n < pe_strb);
        chk("R2 busy", busy, 1'b1);
        chk("R6 done low mid-cycle", done, 1'b0);
        chk("R2 cs0", ata_cs0_n, !(cs_on && !sel));
        chk("R2 cs1", ata_cs1_n, !(cs_on && sel));
        if (cs_on) chk("R10 address", ata_addr, a);
        chk("R3 R4 R5 read strobe", ata_rd_n, !(strb && !wr));
        chk("R3 R4 R5 write strobe", ata_wr_n, !(strb && wr));
        chk("R8 output enable", ata_doe, wr && cs_on);
        if (wr && cs_on) chk("R8 write data", ata_dout, wd);
      end else begin
        chk("R6 done pulse", done, 1'b1);
        chk("R6 busy low with done", busy, 1'b0);
        chk("R6 cs released", {ata_cs0_n, ata_cs1_n}, 2'b11);
        chk("R5 timeout flag", done_tmo, exp_tmo);
        if (!wr) chk("R7 read data", done_rdata, rd);
      end
      // Inputs for the cycle now running (sampled at its closing edge).
      ata_rdy = !((n >= e1) && (n < e1 + e2 + lat - 1));
      ata_din = (n == pe_strb - 1) ? rd : ~rd;
    end
    ata_rdy = 1'b1;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    rst_n = 1'b0; req = 1'b0; req_wr = 1'b0; req_sel = 1'b0; req_addr = '0;
    req_wdata = '0; cfg_t1 = 8'd1; cfg_t2 = 8'd1; cfg_t3 = 8'd1; cfg_t4 = 8'd1;
    cfg_tiordy = 10'd1; dev_rst_hold = 1'b0; ata_din = '0; ata_rdy = 1'b1;
    repeat (3) @(negedge clk);
    // R1: reset state
    chk("R1 busy", busy, 1'b0);
    chk("R1 chip selects", {ata_cs0_n, ata_cs1_n}, 2'b11);
    chk("R1 strobes", {ata_rd_n, ata_wr_n}, 2'b11);
    chk("R1 output enable", ata_doe, 1'b0);
    chk("R1 done", done, 1'b0);
    chk("R1 device reset", ata_rst_n, 1'b0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk("R11 device reset released", ata_rst_n, 1'b1);

    run_txn(1'b0, 1'b0, 3'd3, 16'h0000, 16'hA55A, 2, 3, 1, 2, 8, 0, -1); // plain read
    run_txn(1'b1, 1'b1, 3'd5, 16'h1234, 16'h0000, 1, 4, 2, 3, 8, 0, -1); // plain write
    run_txn(1'b0, 1'b1, 3'd7, 16'h0000, 16'h3C0F, 3, 2, 2, 1, 8, 3, -1); // R4 stretched read
    run_txn(1'b1, 1'b0, 3'd1, 16'hBEEF, 16'h0000, 2, 2, 3, 2, 6, 2, -1); // R4 stretched write
    run_txn(1'b0, 1'b0, 3'd2, 16'h0000, 16'h8001, 1, 3, 1, 1, 4, 20, -1); // R5 timeout
    run_txn(1'b0, 1'b0, 3'd2, 16'h0000, 16'h7E7E, 1, 3, 1, 1, 4, 4, -1); // R5 limit just met
    run_txn(1'b0, 1'b1, 3'd0, 16'h0000, 16'h0F0F, 0, 0, 0, 0, 0, 0, -1); // R9 zeros
    run_txn(1'b1, 1'b1, 3'd6, 16'hC3C3, 16'h0000, 0, 0, 0, 0, 0, 5, -1); // R9 zero limit
    run_txn(1'b1, 1'b0, 3'd4, 16'h5AA5, 16'h0000, 2, 3, 2, 2, 8, 0, 3);  // R10 request while busy
    run_txn(1'b0, 1'b1, 3'd6, 16'h0000, 16'hFACE, 3, 1, 1, 3, 8, 1, 2);  // R10 read variant

    // R11: device reset follows the hold input one edge later
    @(negedge clk);
    dev_rst_hold = 1'b1;
    chk("R11 not yet asserted", ata_rst_n, 1'b1);
    @(negedge clk);
    chk("R11 asserted", ata_rst_n, 1'b0);
    dev_rst_hold = 1'b0;
    @(negedge clk);
    chk("R11 released", ata_rst_n, 1'b1);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule